// File: doc/BRIEF.md
# Successive Approximation Conversion Controller

This block holds the digital control for a successive-approximation converter that reads one of eight analog inputs. A strobe captures a channel address. A start pulse then begins a conversion, which resolves the result one bit at a time, starting at the most significant bit. At each step the block drives a trial code to an external DAC. It reads back a single comparator bit that says whether to keep the trial bit or drop it.

When the last bit is settled, the controller copies the code into an output latch and raises an end-of-conversion flag. The latched code appears on the parallel output only while output enable is high. The analog multiplexer, the DAC and the comparator sit outside the block. The resolution is a parameter, 8 bits by default, and the same sequence works at 12 bits.

Top module: `sar_conv_ctrl`

## Requirements
- R1: During synchronous active-low reset, `ch_sel`, `trial_code`, `conv_done`, `data_out` and `data_ok` all go to zero.
- R2: `ch_sel` takes the value of `ch_addr` at any clock edge where `addr_strobe` is 1, and holds its value at every other edge.
- R3: A start is accepted at an edge where `start` is 1 and no conversion is running. In the next cycle `trial_code` is all zeros (clear step) and `conv_done` is 0.
- R4: In the cycle after the clear step, `trial_code` has only its most significant bit set.
- R5: At each comparison edge the current trial bit is kept when `cmp_keep` is 1 and cleared when it is 0. Unless that bit was bit 0, the next lower bit is then set in `trial_code`.
- R6: `conv_done` rises exactly RES+1 clock edges after the accepting edge. With an ideal comparator (`cmp_keep` = trial <= input), the latched result equals the input code.
- R7: A start pulse while a conversion is running has no effect on the trial sequence or on the cycle in which `conv_done` rises.
- R8: While `out_en` is 1, `data_out` shows the latched result. `data_ok` is 1 once any conversion has completed since reset. While `out_en` is 0, both are zero.
- R9: `conv_done` and the latched result hold until the next accepted start (flag) or the next completion (result).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| addr_strobe | input | 1 | Captures `ch_addr` when 1 |
| ch_addr | input | 3 | Channel address |
| start | input | 1 | Conversion request |
| cmp_keep | input | 1 | Comparator: 1 when the DAC level is not above the input |
| out_en | input | 1 | Output enable for the parallel port |
| ch_sel | output | 3 | Latched channel, drives the analog multiplexer |
| trial_code | output | RES | Trial code to the DAC |
| conv_done | output | 1 | End-of-conversion flag |
| data_out | output | RES | Latched result, zero while `out_en` is 0 |
| data_ok | output | 1 | Output valid indication |

## Verification
The bench attacks the full-scale and zero-scale inputs and codes with alternating bits. A wrong keep/discard polarity or an off-by-one bit walk would return the complement of the input or a shifted code. It sends a start in the middle of a conversion; a design that restarted would raise `conv_done` late and corrupt the trial sequence. It toggles output enable and moves the address without a strobe. A leaking output would then show data while disabled, and a transparent address latch would switch the channel mid-way. A behavioural model checks every cycle, so a clear step that is skipped or doubled shows up as a timing mismatch.

// File: rtl/sar_pkg.sv
// Shared types for the successive-approximation controller.
package sar_pkg;
    typedef enum logic [1:0] {
        PH_IDLE  = 2'd0,
        PH_SETUP = 2'd1,
        PH_CONV  = 2'd2
    } sar_phase_e;
endpackage

// File: rtl/sar_chan_latch.sv
// Channel address latch: captures the address on the strobe and holds it otherwise.
// Assumes the strobe is synchronous to clk.
module sar_chan_latch #(
    parameter int CH_W = 3
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            addr_strobe,
    input  logic [CH_W-1:0] ch_addr,
    output logic [CH_W-1:0] ch_sel
);
    // Capture the channel address when the strobe is high.
    always_ff @(posedge clk) begin
        if (!rst_n)
            ch_sel <= '0;
        else if (addr_strobe)
            ch_sel <= ch_addr;
    end

    a_r2_capture: assert property (@(posedge clk) disable iff (!rst_n)
        addr_strobe |=> ch_sel == $past(ch_addr));
    a_r2_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !addr_strobe |=> $stable(ch_sel));
endmodule

// File: rtl/sar_seq.sv
// Bit sequencer: clear step, then MSB-first trial and keep/discard per bit.
// Assumes cmp_keep settles within one cycle of trial_code changing.
module sar_seq
    import sar_pkg::*;
#(
    parameter int RES = 8
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           start,
    input  logic           cmp_keep,
    output logic [RES-1:0] trial_code,
    output logic           accept,
    output logic           finish,
    output logic [RES-1:0] final_code
);
    localparam logic [RES-1:0] MSB_ONLY = {1'b1, {(RES-1){1'b0}}};

    sar_phase_e     phase_q;
    logic [RES-1:0] sar_q;
    logic [RES-1:0] mask_q;
    logic [RES-1:0] resolved;

    assign accept     = start && (phase_q == PH_IDLE);
    assign resolved   = cmp_keep ? sar_q : (sar_q & ~mask_q);
    assign finish     = (phase_q == PH_CONV) && mask_q[0];
    assign final_code = resolved;
    assign trial_code = sar_q;

    // Step the phase, the approximation register and the bit mask.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            phase_q <= PH_IDLE;
            sar_q   <= '0;
            mask_q  <= '0;
        end else begin
            unique case (phase_q)
                PH_IDLE: begin
                    if (start) begin
                        phase_q <= PH_SETUP;
                        sar_q   <= '0;
                        mask_q  <= '0;
                    end
                end
                PH_SETUP: begin
                    phase_q <= PH_CONV;
                    sar_q   <= MSB_ONLY;
                    mask_q  <= MSB_ONLY;
                end
                PH_CONV: begin
                    if (mask_q[0]) begin
                        phase_q <= PH_IDLE;
                        sar_q   <= resolved;
                        mask_q  <= '0;
                    end else begin
                        sar_q  <= resolved | (mask_q >> 1);
                        mask_q <= mask_q >> 1;
                    end
                end
                default: phase_q <= PH_IDLE;
            endcase
        end
    end

    a_r3_clear_step: assert property (@(posedge clk) disable iff (!rst_n)
        accept |=> trial_code == '0);
    a_r4_msb_first: assert property (@(posedge clk) disable iff (!rst_n)
        phase_q == PH_SETUP |=> trial_code == MSB_ONLY);
    a_r5_mask_onehot: assert property (@(posedge clk) disable iff (!rst_n)
        phase_q == PH_CONV |-> $onehot(mask_q));
    a_r5_keep_bit: assert property (@(posedge clk) disable iff (!rst_n)
        (phase_q == PH_CONV) && cmp_keep |=> (trial_code & $past(mask_q)) != '0);
    a_r5_drop_bit: assert property (@(posedge clk) disable iff (!rst_n)
        (phase_q == PH_CONV) && !cmp_keep |=> (trial_code & $past(mask_q)) == '0);
    a_r7_busy_ignores_start: assert property (@(posedge clk) disable iff (!rst_n)
        (phase_q != PH_IDLE) && start |-> !accept);
endmodule

// File: rtl/sar_out_latch.sv
// Result latch, end-of-conversion flag and gated parallel output.
// Assumes accept and finish are never high in the same cycle.
module sar_out_latch #(
    parameter int RES = 8
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           accept,
    input  logic           finish,
    input  logic [RES-1:0] final_code,
    input  logic           out_en,
    output logic           conv_done,
    output logic [RES-1:0] data_out,
    output logic           data_ok
);
    logic [RES-1:0] result_q;
    logic           have_q;

    // Store the result and set the flag at the end; clear the flag on a new start.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            result_q  <= '0;
            have_q    <= 1'b0;
            conv_done <= 1'b0;
        end else begin
            if (finish) begin
                result_q  <= final_code;
                have_q    <= 1'b1;
                conv_done <= 1'b1;
            end else if (accept) begin
                conv_done <= 1'b0;
            end
        end
    end

    // Present data only while enabled.
    always_comb begin
        data_out = out_en ? result_q : '0;
        data_ok  = out_en && have_q;
    end

    a_r6_flag_on_finish: assert property (@(posedge clk) disable iff (!rst_n)
        finish |=> conv_done);
    a_r8_quiet_when_off: assert property (@(posedge clk) disable iff (!rst_n)
        !out_en |-> (data_out == '0) && !data_ok);
    a_r9_flag_hold: assert property (@(posedge clk) disable iff (!rst_n)
        conv_done && !accept |=> conv_done);
    a_r9_result_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !finish && out_en |=> !out_en || $stable(data_out));
endmodule

// File: rtl/sar_conv_ctrl.sv
// Top: successive-approximation controller with channel latch and gated output.
// Assumes the external mux, DAC and comparator settle within one clock.
module sar_conv_ctrl #(
    parameter int RES  = 8,
    parameter int N_CH = 8,
    localparam int CH_W = $clog2(N_CH)
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            addr_strobe,
    input  logic [CH_W-1:0] ch_addr,
    input  logic            start,
    input  logic            cmp_keep,
    input  logic            out_en,
    output logic [CH_W-1:0] ch_sel,
    output logic [RES-1:0]  trial_code,
    output logic            conv_done,
    output logic [RES-1:0]  data_out,
    output logic            data_ok
);
    logic           accept;
    logic           finish;
    logic [RES-1:0] final_code;

    sar_chan_latch #(.CH_W(CH_W)) chan_i (
        .clk(clk), .rst_n(rst_n), .addr_strobe(addr_strobe),
        .ch_addr(ch_addr), .ch_sel(ch_sel)
    );

    sar_seq #(.RES(RES)) seq_i (
        .clk(clk), .rst_n(rst_n), .start(start), .cmp_keep(cmp_keep),
        .trial_code(trial_code), .accept(accept), .finish(finish),
        .final_code(final_code)
    );

    sar_out_latch #(.RES(RES)) out_i (
        .clk(clk), .rst_n(rst_n), .accept(accept), .finish(finish),
        .final_code(final_code), .out_en(out_en), .conv_done(conv_done),
        .data_out(data_out), .data_ok(data_ok)
    );

    a_r6_no_overlap: assert property (@(posedge clk) disable iff (!rst_n)
        !(accept && finish));
endmodule

// File: tb/sar_conv_ctrl_tb_top.sv
module sar_conv_ctrl_tb_top;
    localparam int RES = 8;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic addr_strobe = 1'b0;
    logic [2:0] ch_addr = '0;
    logic start = 1'b0;
    logic out_en = 1'b0;
    logic cmp_keep;
    logic [2:0] ch_sel;
    logic [RES-1:0] trial_code, data_out;
    logic conv_done, data_ok;

    int n_cmp = 0;
    int n_bad = 0;
    int vin [8];

    always #2 clk = ~clk;

    sar_conv_ctrl #(.RES(RES), .N_CH(8)) dut_i (
        .clk(clk), .rst_n(rst_n), .addr_strobe(addr_strobe), .ch_addr(ch_addr),
        .start(start), .cmp_keep(cmp_keep), .out_en(out_en), .ch_sel(ch_sel),
        .trial_code(trial_code), .conv_done(conv_done), .data_out(data_out),
        .data_ok(data_ok)
    );

    // Ideal comparator and analog mux model.
    always_comb cmp_keep = (int'(trial_code) <= vin[ch_sel]);

    // Behavioural reference model.
    int m_phase = 0, m_trial = 0, m_bit = 0, m_res = 0, m_ch = 0;
    bit m_eoc = 0, m_have = 0, m_first = 0;
    always @(posedge clk) begin
        if (!rst_n) begin
            m_phase = 0; m_trial = 0; m_bit = 0; m_res = 0; m_ch = 0;
            m_eoc = 0; m_have = 0; m_first = 0;
        end else begin
            m_first = 0;
            case (m_phase)
                0: if (start) begin m_phase = 1; m_trial = 0; m_eoc = 0; end
                1: begin
                    m_phase = 2; m_bit = RES - 1; m_trial = 1 << (RES - 1); m_first = 1;
                end
                default: begin
                    if (!(m_trial <= vin[m_ch])) m_trial = m_trial & ~(1 << m_bit);
                    if (m_bit == 0) begin
                        m_res = m_trial; m_have = 1; m_eoc = 1; m_phase = 0;
                    end else begin
                        m_bit = m_bit - 1;
                        m_trial = m_trial | (1 << m_bit);
                    end
                end
            endcase
            if (addr_strobe) m_ch = int'(ch_addr);
        end
    end

    task automatic check(input string tag, input int act, input int exp);
        n_cmp++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s: actual %0d expected %0d at %0t", tag, act, exp, $time);
        end
    endtask

    // Compare every cycle, away from the active edge.
    always @(negedge clk) begin
        if (rst_n) begin
            check("R2 ch_sel", int'(ch_sel), m_ch);
            check(m_phase == 1 ? "R3 trial" : (m_first ? "R4 trial" : "R5 trial"),
                  int'(trial_code), m_trial);
            check("R6 conv_done", int'(conv_done), int'(m_eoc));
            check("R8 data_out", int'(data_out), out_en ? m_res : 0);
            check("R8 data_ok", int'(data_ok), int'(out_en && m_have));
        end
    end

    task automatic tick(); @(posedge clk); #1; endtask

    task automatic convert(input int ch, input bit poke);
        addr_strobe = 1'b1; ch_addr = 3'(ch); tick();
        addr_strobe = 1'b0; ch_addr = 3'(7 - ch); start = 1'b1; tick();
        start = 1'b0;
        for (int i = 0; i < RES; i++) begin
            if (poke && i == 3) start = 1'b1;  // R7 start while busy
            tick();
            start = 1'b0;
            check("R6 no early done", int'(conv_done), 0);
        end
        tick();
        check("R6 done on time", int'(conv_done), 1);
        out_en = 1'b1; #0;
        #1 check("R6 result", int'(data_out), vin[ch]);
        check("R2 ch held", int'(ch_sel), ch);
    endtask

    initial begin
        vin = '{0: 0, 1: 255, 2: 128, 3: 127, 4: 1, 5: 85, 6: 170, 7: 200};
        repeat (3) @(posedge clk);
        #1;
        check("R1 ch_sel", int'(ch_sel), 0);
        check("R1 trial", int'(trial_code), 0);
        check("R1 done", int'(conv_done), 0);
        check("R1 data_out", int'(data_out), 0);
        check("R1 data_ok", int'(data_ok), 0);
        rst_n = 1'b1;
        tick();
        for (int c = 0; c < 8; c++) begin
            out_en = 1'b0;
            convert(c, c == 5);
            tick();
            out_en = 1'b0; #1;
            check("R8 off data", int'(data_out), 0);
            check("R8 off ok", int'(data_ok), 0);
            repeat (3) tick();
            check("R9 flag held", int'(conv_done), 1);
        end
        out_en = 1'b1;
        vin[2] = 3;
        convert(2, 1'b1);
        repeat (4) tick();
        check("R9 result held", int'(data_out), 3);
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        n_bad++;
        $display("FAIL watchdog: actual timeout expected finish");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end
endmodule